// File: doc/BRIEF.md
# Multi-Channel Interval Timer

A register-mapped peripheral holding `NCH` independent down-counting timer channels. Each channel has a control word, an initial-count register and a read-only view of its live count. Counting is gated by a per-channel prescaler. A channel runs either periodically, reloading itself on every expiry, or as a single shot that stops and drops its own enable bit. Every expiry sets the channel's bit in one shared status word. Software clears that bit by writing a one to it. Each channel drives its own interrupt line, qualified by its interrupt-enable bit.

Software reaches the block through a single-cycle synchronous port. A write takes effect at the clock edge where `we` is high. Reads are combinational from `addr`. For a one-shot, software loads a count and then sets the enable bit. To re-arm after an expiry, it writes a new count and sets the enable bit again.

Top module: `pit_timer`

## Requirements
- R1: The control word has count enable at bit 30, interrupt enable at bit 29, the mode at bits 28:27 and the prescale at bits 7:0. It reads back exactly these fields, and every other bit reads as 0.
- R2: Word address `4*c + s` selects a register of channel c: s=0 is control, s=1 is the initial count, s=2 is the live count and s=3 reads 0. Writes to s=2 and s=3 have no effect. The status word sits at address `4*NCH`, with bit c belonging to channel c.
- R3: A control write with bit 30 set loads the live count from the initial count and restarts the prescaler, even when the channel is already running.
- R4: While enabled, the live count drops by one every prescale+1 clocks (prescale 0x63 gives one step per 100 clocks).
- R5: When a step is due and the live count is 1 or 0, the channel expires and sets its status bit.
- R6: Mode 01 is periodic. On expiry the live count reloads from the initial count and counting continues, so the period is initial count × (prescale+1) clocks.
- R7: Modes 00, 10 and 11 are one-shot. On expiry the live count becomes 0 and bit 30 clears in hardware. Writing a new count and setting bit 30 again re-arms the channel.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R9: `irq[c]` is high exactly when status bit c is set and the channel's interrupt enable is set.
- R10: Writing 0 to a control word stops the channel. The live count holds, and no expiry occurs, including one that would have fallen in the cycle of that write.
- R11: 0xFFFFFFFF is a legal initial count. Writing the initial count does not disturb a running count; the new value is used at the next load or reload.
- R12: After reset, all registers, status bits and interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe for the register port |
| addr | input | AW | Word address (AW = clog2(NCH+1)+2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
The bench builds the block with its defaults: five channels, 32-bit counters and an 8-bit prescale. This puts the top status bit and the all-ones count within reach. Short initial counts at prescale 0 and 3 place expiries a few cycles apart. This allows exact-cycle checks of reload, hardware stop and a set colliding with a clear. One run at prescale 0x63 spans 300 cycles, confirming the divide-by-100 step down to the boundary cycle.

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int NCH   = 5,
  parameter int CNT_W = 32,
  parameter int PSC_W = 8,
  localparam int AW   = $clog2(NCH + 1) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [NCH-1:0]   irq
);
  localparam int EN_B = 30;
  localparam int IE_B = 29;
  localparam int MD_H = 28;
  localparam int MD_L = 27;
  localparam logic [AW-1:0] STAT_A = AW'(NCH * 4);

  logic [NCH-1:0]   en_q, ie_q, flag_q, evt, tick, per, wr_ctl, wr_ini;
  logic [1:0]       mode_q [NCH];
  logic [PSC_W-1:0] psc_q  [NCH];
  logic [PSC_W-1:0] pcnt_q [NCH];
  logic [CNT_W-1:0] init_q [NCH];
  logic [CNT_W-1:0] cnt_q  [NCH];
  logic             stat_wr;

  assign stat_wr = we && (addr == STAT_A);
  assign irq     = flag_q & ie_q;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      wr_ctl[i] = we && (addr == AW'(i * 4));
      wr_ini[i] = we && (addr == AW'(i * 4 + 1));
      per[i]    = (mode_q[i] == 2'b01);
      tick[i]   = en_q[i] && (pcnt_q[i] == psc_q[i]);
      evt[i]    = tick[i] && !wr_ctl[i] && (cnt_q[i] <= CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      ie_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        mode_q[i] <= '0;
        psc_q[i]  <= '0;
        pcnt_q[i] <= '0;
        init_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_ini[i]) init_q[i] <= wdata[CNT_W-1:0];
        if (wr_ctl[i]) begin
          en_q[i]   <= wdata[EN_B];
          ie_q[i]   <= wdata[IE_B];
          mode_q[i] <= wdata[MD_H:MD_L];
          psc_q[i]  <= wdata[PSC_W-1:0];
          pcnt_q[i] <= '0;
          if (wdata[EN_B]) cnt_q[i] <= init_q[i];
        end else if (en_q[i]) begin
          if (tick[i]) begin
            pcnt_q[i] <= '0;
            if (evt[i]) begin
              if (per[i]) cnt_q[i] <= init_q[i];
              else begin
                cnt_q[i] <= '0;
                en_q[i]  <= 1'b0;
              end
            end else begin
              cnt_q[i] <= cnt_q[i] - CNT_W'(1);
            end
          end else begin
            pcnt_q[i] <= pcnt_q[i] + PSC_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~(stat_wr ? wdata[NCH-1:0] : '0)) | evt;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i * 4)) begin
        rdata[EN_B]        = en_q[i];
        rdata[IE_B]        = ie_q[i];
        rdata[MD_H:MD_L]   = mode_q[i];
        rdata[PSC_W-1:0]   = psc_q[i];
      end
      if (addr == AW'(i * 4 + 1)) rdata[CNT_W-1:0] = init_q[i];
      if (addr == AW'(i * 4 + 2)) rdata[CNT_W-1:0] = cnt_q[i];
    end
    if (addr == STAT_A) rdata[NCH-1:0] = flag_q;
  end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int NCH = 5,
  parameter int AW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           we,
  input logic [AW-1:0]  addr,
  input logic [31:0]    wdata,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] evt,
  input logic [NCH-1:0] per
);
  localparam logic [AW-1:0] STAT_A = AW'(NCH * 4);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == STAT_A && wdata[g] && !evt[g]) |=> !flags[g]);
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !(we && addr == STAT_A && wdata[g])) |=> flags[g]);
    assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[g]) |-> $past(evt[g]));
    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[g] && !per[g]) |=> !en[g]);
    assert_periodic_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[g] && per[g]) |=> en[g]);
  end
endmodule

bind pit_timer pit_timer_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .flags(flag_q), .en(en_q), .evt(evt), .per(per)
);

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;
  localparam int NCH = 5;
  localparam int AW  = 5;
  localparam logic [AW-1:0] ST = 5'd20;

  logic clk = 0, rst_n = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pit_timer u0 (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
                .wdata(wdata), .rdata(rdata), .irq(irq));

  localparam logic [68:0] VEC [8] = '{
    {5'd0,  32'hFFFF_FFFF, 32'h7800_00FF},
    {5'd0,  32'h0000_0000, 32'h0000_0000},
    {5'd5,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {5'd8,  32'h0000_1234, 32'h0000_0034},
    {5'd3,  32'h0000_DEAD, 32'h0000_0000},
    {5'd6,  32'h0000_0055, 32'h0000_0000},
    {5'd8,  32'h2800_0000, 32'h2800_0000},
    {5'd20, 32'h0000_001F, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(posedge clk);
    @(negedge clk);
    we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rchk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    rchk("R12 status", ST, 0);
    rchk("R12 ctrl0", 0, 0);
    rchk("R12 count4", 18, 0);
    chk("R12 irq", 32'(irq), 0);

    for (int k = 0; k < 8; k++) begin
      wr(VEC[k][68:64], VEC[k][63:32]);
      rchk("R1/R2/R11 vector", VEC[k][68:64], VEC[k][31:0]);
    end

    // R3 R4 R5 R6 R9: periodic ch0, init 4, prescale 0
    wr(1, 4);
    wr(0, 32'h6800_0000);
    rchk("R3 load", 2, 4);
    repeat (2) @(negedge clk);
    rchk("R4 step", 2, 2);
    repeat (2) @(negedge clk);
    rchk("R5 flag", ST, 32'h1);
    chk("R9 irq0", 32'(irq), 32'h1);
    rchk("R6 reload", 2, 4);
    wr(ST, 32'h1);
    rchk("R8 clear", ST, 0);
    rchk("R6 running", 2, 3);
    repeat (3) @(negedge clk);
    rchk("R6 period", ST, 32'h1);
    // R10 stop
    wr(0, 0);
    rchk("R10 hold", 2, 4);
    wr(ST, 32'h1);
    repeat (10) @(negedge clk);
    rchk("R10 no event", ST, 0);
    rchk("R10 still held", 2, 4);

    // R7 one-shot ch1, prescale 3, no interrupt enable
    wr(5, 2);
    wr(4, 32'h4000_0003);
    rchk("R3 load ch1", 6, 2);
    repeat (4) @(negedge clk);
    rchk("R4 prescale step", 6, 1);
    repeat (3) @(negedge clk);
    rchk("R4 prescale wait", 6, 1);
    repeat (1) @(negedge clk);
    rchk("R7 count zero", 6, 0);
    rchk("R5 flag ch1", ST, 32'h2);
    chk("R9 irq masked", 32'(irq), 0);
    rchk("R7 enable cleared", 4, 32'h0000_0003);
    repeat (20) @(negedge clk);
    rchk("R7 stays stopped", 6, 0);
    wr(ST, 32'h0);
    rchk("R8 zero write keeps", ST, 32'h2);
    wr(ST, 32'h2);
    wr(5, 3);
    wr(4, 32'h6000_0000);
    repeat (3) @(negedge clk);
    rchk("R7 rearm flag", ST, 32'h2);
    chk("R9 irq1", 32'(irq), 32'h2);
    rchk("R7 rearm stop", 4, 32'h2000_0000);
    wr(ST, 32'h2);
    chk("R9 irq drops", 32'(irq), 0);

    // R7 reserved mode 11 acts as one-shot
    wr(9, 1);
    wr(8, 32'h5800_0000);
    rchk("R3 load ch2", 10, 1);
    repeat (1) @(negedge clk);
    rchk("R7 mode11 count", 10, 0);
    rchk("R7 mode11 stop", 8, 32'h1800_0000);
    rchk("R7 mode11 flag", ST, 32'h4);
    wr(ST, 32'h4);

    // R8 set wins over clear, R10 stop during expiry cycle
    wr(13, 2);
    wr(12, 32'h4800_0000);
    repeat (1) @(negedge clk);
    wr(ST, 32'h8);
    rchk("R8 set wins", ST, 32'h8);
    wr(ST, 32'h8);
    rchk("R8 cleared", ST, 0);
    wr(12, 0);
    rchk("R10 stop beats expiry", ST, 0);

    // R4 prescale 0x63 on top channel
    wr(17, 3);
    wr(16, 32'h4800_0063);
    repeat (299) @(negedge clk);
    rchk("R4 div100 before", ST, 0);
    repeat (1) @(negedge clk);
    rchk("R4 div100 edge", ST, 32'h10);
    wr(16, 0);
    wr(ST, 32'h10);

    // R11 init write while running
    wr(1, 5);
    wr(0, 32'h4800_0000);
    wr(1, 100);
    rchk("R11 undisturbed", 2, 4);
    repeat (4) @(negedge clk);
    rchk("R11 new reload", 2, 100);
    wr(0, 0);
    wr(ST, 32'h1F);
    rchk("R8 all clear", ST, 0);

    finish_run();
  end
endmodule